// File: doc/BRIEF.md
# I2C DAC Bring-Up Sequencer

This block powers up a 12-bit voltage-output DAC on an I2C bus with no processor involved. It sits in front of an I2C byte master and drives that master's command interface. Each command is a single-cycle pulse: bus START, bus STOP, write one byte, or read one byte. The master raises its busy flag in the cycle after a command and lowers it when the command has finished. When a write finishes, the master also reports whether the byte was acknowledged.

A single-cycle pulse on `start_i` loads the settings from the input pins: sub-address, reference select, power-down mode, gain select and output code. The block then runs three bus transactions in a fixed order:

1. It reads the status of the device. Only the first byte read back is decoded, into a ready flag and a power-on flag.
2. It writes the volatile configuration byte.
3. It writes the 12-bit output code in two bytes.

A missing acknowledge ends the run early. `done_o` pulses for one cycle at the end of every run, and `err_o` tells whether the run failed.

The controller is a state machine with these states:

- `S_IDLE`: waits for a start pulse.
- `S_BEGIN`: issues a bus START.
- `S_ADDR`: sends the address byte.
- `S_XFER`: moves one data byte, a read or a write.
- `S_HALT`: issues a bus STOP.
- `S_WAIT`: lets the master raise busy, then waits for busy to clear.
- `S_DONE`: pulses `done_o` for one cycle.

Its transitions are:

- IDLE→BEGIN on a start pulse.
- Every issuing state goes to WAIT.
- WAIT→ADDR after a START has finished.
- WAIT→XFER after an acknowledged address byte, and after each data byte that is not the last of its transaction.
- WAIT→HALT after a missing acknowledge, or after the last data byte.
- WAIT→BEGIN after a STOP while a transaction is still pending.
- WAIT→DONE after the last STOP, or after the STOP that follows an error.
- DONE→IDLE always.

Top module: `dac_init_seq`

## Requirements
- R1: After a start pulse the block runs three transactions in this order: a status read, a configuration write, a value write. Each transaction is a bus START, an address byte, its data bytes and a bus STOP.
- R2: The address byte holds the 7-bit address 0x60 + `sub_addr_i` in bits 7:1. Bit 0 is 1 for the status read and 0 for both writes.
- R3: The configuration write sends a single byte: bit 7 is 1, bits 6:5 are 0, bits 4:3 carry the reference select, bits 2:1 carry the power-down mode, and bit 0 carries the gain select. The reference encodings are 00 for unbuffered supply, 10 for unbuffered reference and 11 for buffered reference. The power-down encodings are 00 for normal, 01 for a 1k load, 10 for a 100k load and 11 for a 500k load.
- R4: The value write sends two bytes. The first is {2'b00, power-down mode, code[11:8]}. The second is code[7:0]. The power-down mode in the first byte is the one sent in the configuration byte of the same run.
- R5: All settings are sampled on the accepted start pulse. Changing the setting inputs during a run has no effect on any byte sent.
- R6: The status read issues exactly RD_BYTES read commands (default 6, allowed range 1 to 6). From the first byte read, bit 7 goes to `stat_ready_o` and bit 6 goes to `stat_por_o`. Both status outputs read 0 from the start of a run until that first byte arrives.
- R7: A missing acknowledge on any written byte stops the run. The block then issues only a bus STOP, raises `err_o`, and issues no further read or write commands. `err_o` stays high until the next start.
- R8: `done_o` pulses for exactly one cycle, once per run, after the final STOP has finished. This holds for a successful run and for a failed one.
- R9: At most one command is issued per cycle. No command is issued while the master is busy.
- R10: A start pulse that arrives while a run is in progress is ignored.
- R11: During and after reset, no command is issued, and `done_o`, `err_o`, `stat_ready_o` and `stat_por_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Start pulse for a bring-up run |
| sub_addr_i | input | 3 | Device sub-address |
| vref_sel_i | input | 2 | Reference select code |
| pd_mode_i | input | 2 | Power-down mode code |
| gain2x_i | input | 1 | Gain-of-two select |
| code_i | input | 12 | DAC output code |
| cmd_start_o | output | 1 | Command pulse: bus START |
| cmd_stop_o | output | 1 | Command pulse: bus STOP |
| cmd_write_o | output | 1 | Command pulse: write `cmd_wdata_o` |
| cmd_read_o | output | 1 | Command pulse: read one byte |
| cmd_wdata_o | output | 8 | Byte to be written |
| mst_busy_i | input | 1 | Master is busy with a command |
| mst_nack_i | input | 1 | The last written byte was not acknowledged |
| mst_rdata_i | input | 8 | The last byte read |
| done_o | output | 1 | One-cycle pulse at the end of a run |
| err_o | output | 1 | The run ended on a missing acknowledge |
| stat_ready_o | output | 1 | Decoded ready flag from the status byte |
| stat_por_o | output | 1 | Decoded power-on flag from the status byte |

## Verification
The assertions assume that the master raises busy in the cycle right after a command and holds it until the command has finished. They also assume that the acknowledge result and the read byte are valid when busy falls. The rules that no command is issued while busy, and that each run ends in a single done pulse, rest on these assumptions. The bench's master model keeps to this contract by asserting busy on the edge that samples a command and holding it for a fixed latency. It sets the acknowledge flag and the read data on the same edge where busy falls. The bench drives the inputs only on falling edges, and it raises a start pulse during a run only to test that such a pulse is ignored.

// File: rtl/dac_seq_pkg.sv
package dac_seq_pkg;

    localparam int BYTE_W = 8;
    localparam logic [6:0] DEV_ADDR_BASE = 7'h60;

    typedef enum logic [2:0] {
        S_IDLE,
        S_BEGIN,
        S_ADDR,
        S_XFER,
        S_HALT,
        S_WAIT,
        S_DONE
    } seq_state_t;

    typedef enum logic [1:0] {
        PH_STAT,
        PH_CFG,
        PH_VAL
    } seq_phase_t;

    typedef enum logic [1:0] {
        OP_START,
        OP_ADDR,
        OP_DATA,
        OP_STOP
    } seq_op_t;

endpackage

// File: rtl/dac_frame_fmt.sv
module dac_frame_fmt
    import dac_seq_pkg::*;
#(
    parameter int SUB_W  = 3,
    parameter int CODE_W = 12,
    parameter int IDX_W  = 3
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  load_i,
    input  logic [SUB_W-1:0]      sub_i,
    input  logic [1:0]            vref_i,
    input  logic [1:0]            pd_i,
    input  logic                  gain_i,
    input  logic [CODE_W-1:0]     code_i,
    input  seq_phase_t            phase_i,
    input  logic [IDX_W-1:0]      idx_i,
    input  logic                  sel_addr_i,
    output logic [BYTE_W-1:0]     byte_o
);

    localparam int HI_W = CODE_W - 8;

    logic [SUB_W-1:0]  sub_q;
    logic [1:0]        vref_q;
    logic [1:0]        pd_q;
    logic              gain_q;
    logic [CODE_W-1:0] code_q;
    logic [6:0]        dev_addr;

    // Settings are captured once per run so every byte agrees with the others.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sub_q  <= '0;
            vref_q <= '0;
            pd_q   <= '0;
            gain_q <= 1'b0;
            code_q <= '0;
        end else if (load_i) begin
            sub_q  <= sub_i;
            vref_q <= vref_i;
            pd_q   <= pd_i;
            gain_q <= gain_i;
            code_q <= code_i;
        end
    end

    assign dev_addr = DEV_ADDR_BASE + 7'(sub_q);

    always_comb begin
        byte_o = '0;
        if (sel_addr_i) begin
            byte_o = {dev_addr, (phase_i == PH_STAT)};
        end else begin
            unique case (phase_i)
                PH_CFG:  byte_o = {3'b100, vref_q, pd_q, gain_q};
                PH_VAL:  byte_o = (idx_i == '0) ?
                                  {2'b00, pd_q, HI_W'(code_q[CODE_W-1:8])} :
                                  code_q[7:0];
                default: byte_o = '0;
            endcase
        end
    end

endmodule

// File: rtl/dac_status_cap.sv
module dac_status_cap
    import dac_seq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear_i,
    input  logic              cap_i,
    input  logic [BYTE_W-1:0] rdata_i,
    output logic              ready_o,
    output logic              por_o
);

    always_ff @(posedge clk) begin
        if (!rst_n || clear_i) begin
            ready_o <= 1'b0;
            por_o   <= 1'b0;
        end else if (cap_i) begin
            ready_o <= rdata_i[7];
            por_o   <= rdata_i[6];
        end
    end

endmodule

// File: rtl/dac_seq_ctrl.sv
module dac_seq_ctrl
    import dac_seq_pkg::*;
#(
    parameter int RD_BYTES = 6,
    parameter int IDX_W    = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             mst_busy_i,
    input  logic             mst_nack_i,
    output logic             cmd_start_o,
    output logic             cmd_stop_o,
    output logic             cmd_write_o,
    output logic             cmd_read_o,
    output logic             sel_addr_o,
    output seq_phase_t       phase_o,
    output logic [IDX_W-1:0] idx_o,
    output logic             load_o,
    output logic             cap_o,
    output logic             done_o,
    output logic             err_o
);

    localparam logic [IDX_W-1:0] LAST_STAT = IDX_W'(RD_BYTES - 1);
    localparam logic [IDX_W-1:0] LAST_CFG  = IDX_W'(0);
    localparam logic [IDX_W-1:0] LAST_VAL  = IDX_W'(1);

    seq_state_t       state_q, state_n;
    seq_phase_t       phase_q, phase_n;
    seq_op_t          op_q, op_n;
    logic [IDX_W-1:0] idx_q, idx_n;
    logic             err_q, err_n;
    logic             settled_q, settled_n;
    logic [IDX_W-1:0] last_idx;
    logic             step_ok;

    always_comb begin
        unique case (phase_q)
            PH_STAT: last_idx = LAST_STAT;
            PH_CFG:  last_idx = LAST_CFG;
            default: last_idx = LAST_VAL;
        endcase
    end

    // A step finishes once the master has had a cycle to raise busy and busy has fallen.
    assign step_ok = (state_q == S_WAIT) && settled_q && !mst_busy_i;

    always_comb begin
        state_n   = state_q;
        phase_n   = phase_q;
        op_n      = op_q;
        idx_n     = idx_q;
        err_n     = err_q;
        settled_n = 1'b1;
        unique case (state_q)
            S_IDLE: begin
                if (start_i) begin
                    state_n = S_BEGIN;
                    phase_n = PH_STAT;
                    err_n   = 1'b0;
                end
            end
            S_BEGIN: begin
                op_n      = OP_START;
                settled_n = 1'b0;
                state_n   = S_WAIT;
            end
            S_ADDR: begin
                op_n      = OP_ADDR;
                settled_n = 1'b0;
                state_n   = S_WAIT;
            end
            S_XFER: begin
                op_n      = OP_DATA;
                settled_n = 1'b0;
                state_n   = S_WAIT;
            end
            S_HALT: begin
                op_n      = OP_STOP;
                settled_n = 1'b0;
                state_n   = S_WAIT;
            end
            S_WAIT: begin
                if (step_ok) begin
                    unique case (op_q)
                        OP_START: state_n = S_ADDR;
                        OP_ADDR: begin
                            if (mst_nack_i) begin
                                err_n   = 1'b1;
                                state_n = S_HALT;
                            end else begin
                                idx_n   = '0;
                                state_n = S_XFER;
                            end
                        end
                        OP_DATA: begin
                            if (phase_q != PH_STAT && mst_nack_i) begin
                                err_n   = 1'b1;
                                state_n = S_HALT;
                            end else if (idx_q == last_idx) begin
                                state_n = S_HALT;
                            end else begin
                                idx_n   = idx_q + 1'b1;
                                state_n = S_XFER;
                            end
                        end
                        default: begin
                            if (err_q || phase_q == PH_VAL) begin
                                state_n = S_DONE;
                            end else begin
                                phase_n = (phase_q == PH_STAT) ? PH_CFG : PH_VAL;
                                state_n = S_BEGIN;
                            end
                        end
                    endcase
                end
            end
            default: state_n = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= S_IDLE;
            phase_q   <= PH_STAT;
            op_q      <= OP_START;
            idx_q     <= '0;
            err_q     <= 1'b0;
            settled_q <= 1'b0;
        end else begin
            state_q   <= state_n;
            phase_q   <= phase_n;
            op_q      <= op_n;
            idx_q     <= idx_n;
            err_q     <= err_n;
            settled_q <= settled_n;
        end
    end

    always_comb begin
        cmd_start_o = (state_q == S_BEGIN);
        cmd_stop_o  = (state_q == S_HALT);
        cmd_write_o = (state_q == S_ADDR) || (state_q == S_XFER && phase_q != PH_STAT);
        cmd_read_o  = (state_q == S_XFER) && (phase_q == PH_STAT);
        sel_addr_o  = (state_q == S_ADDR);
        load_o      = (state_q == S_IDLE) && start_i;
        cap_o       = step_ok && op_q == OP_DATA && phase_q == PH_STAT && idx_q == '0;
        done_o      = (state_q == S_DONE);
        err_o       = err_q;
        phase_o     = phase_q;
        idx_o       = idx_q;
    end

endmodule

// File: rtl/dac_init_seq.sv
module dac_init_seq
    import dac_seq_pkg::*;
#(
    parameter int RD_BYTES = 6,
    parameter int SUB_W    = 3,
    parameter int CODE_W   = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [SUB_W-1:0]  sub_addr_i,
    input  logic [1:0]        vref_sel_i,
    input  logic [1:0]        pd_mode_i,
    input  logic              gain2x_i,
    input  logic [CODE_W-1:0] code_i,
    output logic              cmd_start_o,
    output logic              cmd_stop_o,
    output logic              cmd_write_o,
    output logic              cmd_read_o,
    output logic [7:0]        cmd_wdata_o,
    input  logic              mst_busy_i,
    input  logic              mst_nack_i,
    input  logic [7:0]        mst_rdata_i,
    output logic              done_o,
    output logic              err_o,
    output logic              stat_ready_o,
    output logic              stat_por_o
);

    localparam int IDX_W = (RD_BYTES > 2) ? $clog2(RD_BYTES) : 1;

    seq_phase_t       phase;
    logic [IDX_W-1:0] idx;
    logic             sel_addr;
    logic             load;
    logic             cap;

    dac_seq_ctrl #(
        .RD_BYTES (RD_BYTES),
        .IDX_W    (IDX_W)
    ) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (start_i),
        .mst_busy_i  (mst_busy_i),
        .mst_nack_i  (mst_nack_i),
        .cmd_start_o (cmd_start_o),
        .cmd_stop_o  (cmd_stop_o),
        .cmd_write_o (cmd_write_o),
        .cmd_read_o  (cmd_read_o),
        .sel_addr_o  (sel_addr),
        .phase_o     (phase),
        .idx_o       (idx),
        .load_o      (load),
        .cap_o       (cap),
        .done_o      (done_o),
        .err_o       (err_o)
    );

    dac_frame_fmt #(
        .SUB_W  (SUB_W),
        .CODE_W (CODE_W),
        .IDX_W  (IDX_W)
    ) u_fmt (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (load),
        .sub_i      (sub_addr_i),
        .vref_i     (vref_sel_i),
        .pd_i       (pd_mode_i),
        .gain_i     (gain2x_i),
        .code_i     (code_i),
        .phase_i    (phase),
        .idx_i      (idx),
        .sel_addr_i (sel_addr),
        .byte_o     (cmd_wdata_o)
    );

    dac_status_cap u_stat (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear_i (load),
        .cap_i   (cap),
        .rdata_i (mst_rdata_i),
        .ready_o (stat_ready_o),
        .por_o   (stat_por_o)
    );

endmodule

// File: rtl/dac_init_seq_chk.sv
module dac_init_seq_chk (
    input logic clk,
    input logic rst_n,
    input logic cmd_start_o,
    input logic cmd_stop_o,
    input logic cmd_write_o,
    input logic cmd_read_o,
    input logic mst_busy_i,
    input logic done_o,
    input logic err_o
);

    assert_one_cmd_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({cmd_start_o, cmd_stop_o, cmd_write_o, cmd_read_o}));

    assert_idle_while_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
        mst_busy_i |-> !(cmd_start_o || cmd_stop_o || cmd_write_o || cmd_read_o));

    assert_done_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    assert_done_bus_free_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !mst_busy_i);

    assert_no_xfer_after_err_R7: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |-> !(cmd_write_o || cmd_read_o));

endmodule

bind dac_init_seq dac_init_seq_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cmd_start_o (cmd_start_o),
    .cmd_stop_o  (cmd_stop_o),
    .cmd_write_o (cmd_write_o),
    .cmd_read_o  (cmd_read_o),
    .mst_busy_i  (mst_busy_i),
    .done_o      (done_o),
    .err_o       (err_o)
);

// File: tb/dac_init_seq_tb.sv
module dac_init_seq_tb;

    localparam int RDB = 6;
    localparam int LAT = 3;
    localparam int K_START = 0, K_WR = 1, K_RD = 2, K_STOP = 3;

    // {sub[31:29], vref[28:27], pd[26:25], gain[24], code[23:12], status[11:4], nack_at[3:0]}
    localparam logic [31:0] VEC [6] = '{
        {3'd3, 2'b10, 2'b00, 1'b0, 12'h800, 8'hC0, 4'd0},
        {3'd0, 2'b00, 2'b11, 1'b1, 12'hFFF, 8'h40, 4'd0},
        {3'd7, 2'b11, 2'b01, 1'b0, 12'h001, 8'h80, 4'd0},
        {3'd5, 2'b10, 2'b10, 1'b1, 12'hA5C, 8'hC0, 4'd1},
        {3'd1, 2'b00, 2'b00, 1'b0, 12'h123, 8'hFF, 4'd3},
        {3'd2, 2'b11, 2'b10, 1'b0, 12'h3C7, 8'h3F, 4'd6}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic [2:0] sub = '0;
    logic [1:0] vref = '0, pd = '0;
    logic gain = 1'b0;
    logic [11:0] code = '0;
    logic c_start, c_stop, c_wr, c_rd;
    logic [7:0] wdata;
    logic busy, nack;
    logic [7:0] rdata;
    logic done, err, st_rdy, st_por;

    always #2.5 clk = ~clk;

    dac_init_seq u_dut (
        .clk(clk), .rst_n(rst_n), .start_i(start), .sub_addr_i(sub),
        .vref_sel_i(vref), .pd_mode_i(pd), .gain2x_i(gain), .code_i(code),
        .cmd_start_o(c_start), .cmd_stop_o(c_stop), .cmd_write_o(c_wr),
        .cmd_read_o(c_rd), .cmd_wdata_o(wdata), .mst_busy_i(busy),
        .mst_nack_i(nack), .mst_rdata_i(rdata), .done_o(done), .err_o(err),
        .stat_ready_o(st_rdy), .stat_por_o(st_por)
    );

    // ---------------- byte master model ----------------
    logic       clr_log = 1'b0;
    logic [3:0] nack_at = '0;
    logic [7:0] stat_byte = '0;
    int         ev_n, wr_cnt, rd_idx, cnt;
    logic [1:0] ev_kind [32];
    logic [7:0] ev_byte [32];
    logic       pend_nack;
    logic [7:0] pend_rd;

    always @(posedge clk) begin
        if (!rst_n || clr_log) begin
            busy <= 1'b0; nack <= 1'b0; rdata <= '0; cnt <= 0;
            ev_n <= 0; wr_cnt <= 0; rd_idx <= 0;
            pend_nack <= 1'b0; pend_rd <= '0;
        end else if (c_start || c_stop || c_wr || c_rd) begin
            busy <= 1'b1; cnt <= LAT; nack <= 1'b0; pend_nack <= 1'b0;
            if (ev_n < 32) begin
                ev_kind[ev_n] <= c_start ? 2'(K_START) : c_wr ? 2'(K_WR) :
                                 c_rd ? 2'(K_RD) : 2'(K_STOP);
                ev_byte[ev_n] <= c_wr ? wdata : 8'h00;
                ev_n <= ev_n + 1;
            end
            if (c_start) rd_idx <= 0;
            if (c_wr) begin
                wr_cnt <= wr_cnt + 1;
                pend_nack <= (wr_cnt + 1 == int'(nack_at));
            end
            if (c_rd) begin
                pend_rd <= (rd_idx == 0) ? stat_byte : 8'(8'h11 * rd_idx);
                rd_idx <= rd_idx + 1;
            end
        end else if (busy) begin
            if (cnt == 1) begin
                busy <= 1'b0; nack <= pend_nack; rdata <= pend_rd;
            end
            cnt <= cnt - 1;
        end
    end

    // ---------------- bookkeeping ----------------
    int checks = 0, fails = 0;
    int cyc = 0;
    bit finished = 1'b0;

    task automatic chk(input string req, input bit ok, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000 && !finished) begin
            fails++;
            $display("FAIL watchdog: actual %0d expected %0d", cyc, 150000);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    // ---------------- expected transaction list ----------------
    logic [1:0] exp_kind [32];
    logic [7:0] exp_byte [32];
    int exp_n, exp_wc;
    bit exp_cut;

    task automatic push(input int k, input logic [7:0] b);
        if (!exp_cut) begin
            exp_kind[exp_n] = 2'(k);
            exp_byte[exp_n] = b;
            exp_n++;
            if (k == K_WR) begin
                exp_wc++;
                if (exp_wc == int'(nack_at)) begin
                    exp_kind[exp_n] = 2'(K_STOP);
                    exp_byte[exp_n] = 8'h00;
                    exp_n++;
                    exp_cut = 1'b1;
                end
            end
        end
    endtask

    task automatic build_exp(input logic [31:0] v);
        logic [6:0] a;
        a = 7'h60 + 7'(v[31:29]);
        exp_n = 0; exp_wc = 0; exp_cut = 1'b0;
        push(K_START, 0); push(K_WR, {a, 1'b1});
        for (int i = 0; i < RDB; i++) push(K_RD, 0);
        push(K_STOP, 0);
        push(K_START, 0); push(K_WR, {a, 1'b0});
        push(K_WR, {3'b100, v[28:27], v[26:25], v[24]});
        push(K_STOP, 0);
        push(K_START, 0); push(K_WR, {a, 1'b0});
        push(K_WR, {2'b00, v[26:25], v[23:20]});
        push(K_WR, v[19:12]);
        push(K_STOP, 0);
    endtask

    // Runs one bring-up; restart_at / mutate_at are cycle numbers after start (0 = unused).
    task automatic run(input logic [31:0] v, input int restart_at, input int mutate_at,
                       input string tag);
        int n, dcnt;
        bit seen, err_at_done;
        @(negedge clk);
        {sub, vref, pd, gain, code} = v[31:12];
        stat_byte = v[11:4];
        nack_at = v[3:0];
        clr_log = 1'b1;
        @(negedge clk);
        clr_log = 1'b0;
        build_exp(v);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        n = 1; dcnt = 0; seen = 1'b0; err_at_done = 1'b0;
        while (n < 3000) begin
            if (done) begin
                dcnt++;
                if (!seen) err_at_done = err;
                seen = 1'b1;
            end
            @(negedge clk);
            n++;
            start = (n == restart_at);
            if (n == mutate_at) begin
                sub = ~sub; vref = ~vref; pd = ~pd; gain = ~gain; code = ~code;
            end
            if (seen && !start && n > restart_at + 8) break;
        end
        start = 1'b0;
        chk({tag, " R8 done pulse count"}, dcnt == 1, dcnt, 1);
        chk({tag, " R7 error flag"}, err_at_done == (nack_at != 0), err_at_done, nack_at != 0);
        chk({tag, " R7 error held"}, err == (nack_at != 0), err, nack_at != 0);
        chk({tag, " R1 command count"}, ev_n == exp_n, ev_n, exp_n);
        for (int i = 0; i < exp_n && i < ev_n; i++) begin
            chk({tag, " R1 command kind"}, ev_kind[i] == exp_kind[i], ev_kind[i], exp_kind[i]);
            if (exp_kind[i] == 2'(K_WR))
                chk({tag, " R2/R3/R4 write byte"}, ev_byte[i] == exp_byte[i],
                    ev_byte[i], exp_byte[i]);
        end
        chk({tag, " R6 ready bit"}, st_rdy == ((nack_at != 1) && stat_byte[7]),
            st_rdy, (nack_at != 1) && stat_byte[7]);
        chk({tag, " R6 por bit"}, st_por == ((nack_at != 1) && stat_byte[6]),
            st_por, (nack_at != 1) && stat_byte[6]);
    endtask

    initial begin
        // R11: reset state
        repeat (3) @(negedge clk);
        chk("R11 cmds in reset", !(c_start || c_stop || c_wr || c_rd), {c_start, c_stop, c_wr, c_rd}, 0);
        chk("R11 outputs in reset", {done, err, st_rdy, st_por} == 4'b0, {done, err, st_rdy, st_por}, 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk("R11 idle after reset", !(c_start || c_stop || c_wr || c_rd || done || err),
            {c_start, c_stop, c_wr, c_rd, done, err}, 0);

        // Table of vectors: R1..R4, R6, R7, R8
        for (int i = 0; i < 6; i++) run(VEC[i], 0, 0, $sformatf("vec%0d", i));

        // R10: second start mid-run ignored
        run(VEC[1], 40, 0, "R10 restart");
        // R5: settings changed mid-run have no effect
        run(VEC[2], 0, 5, "R5 mutate early");
        run(VEC[0], 0, 60, "R5 mutate late");
        // R7: nack on value address byte, status kept from read
        run({3'd6, 2'b10, 2'b01, 1'b1, 12'h5A5, 8'hC0, 4'd4}, 0, 0, "R7 nack val addr");
        // R6: status cleared at next start, recovered after error
        run(VEC[1], 0, 0, "R6 recover");

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule